// File: doc/BRIEF.md
# Signed Fractional Multiplier with Corner Clamp

This unit multiplies two signed fractional operands in one of two precisions and returns the product in fractional form. A fractional product is the full two's-complement product moved up by one bit position. This drops the redundant upper sign bit and keeps the binary point aligned with the operands. In narrow precision the low 16 bits of each operand are used and a 32-bit product is formed. In wide precision all 32 bits are used and a 64-bit product is formed. The product output is always 64 bits wide. A narrow result is sign-extended to fill it.

A mode select chooses between wrapping and clamping behaviour. Only one input pair overflows the fractional range: the most negative value times itself, whose true result is +1.0. In clamping mode that pair returns the largest positive fraction of the selected precision and raises the indication flag. In wrapping mode the shifted product is returned unchanged. For every pair other than a clamped one, the flag is the AND of the two most significant bits of the unshifted raw product. Operands, precision and mode are captured on a valid strobe. Result, flag and a matching valid output appear one clock later.

Top module: `frac_mul_sat`

## Requirements
- R1: While reset is asserted, and at the first sample after it is released, `out_valid`, `product` and `sat_flag` are all zero.
- R2: A request taken with `in_valid` high produces `out_valid` high exactly one clock later. A cycle without a request produces `out_valid` low one clock later.
- R3: With `wide_sel`=1, `product` is the 64-bit signed product of `op_a` and `op_b` shifted left by one bit, with the top raw bit discarded and bit 0 equal to zero.
- R4: With `wide_sel`=0, the operands are `op_a[15:0]` and `op_b[15:0]` as signed values. Their 32-bit product shifted left by one is placed in `product[31:0]`, and bits [63:32] repeat bit 31.
- R5: Except for a clamped result, `sat_flag` equals raw[2N-1] AND raw[2N-2] of the unshifted raw product, where N is 16 or 32 per `wide_sel`.
- R6: With `sat_mode`=1, `wide_sel`=0 and both low halves equal to 0x8000, `product` is 0x000000007FFFFFFF and `sat_flag` is 1.
- R7: With `sat_mode`=1, `wide_sel`=1 and both operands equal to 0x80000000, `product` is 0x7FFFFFFFFFFFFFFF and `sat_flag` is 1.
- R8: With `sat_mode`=0 the most-negative pair wraps without clamping. Narrow gives 0xFFFFFFFF80000000 and wide gives 0x8000000000000000, with `sat_flag` 0 in both cases.
- R9: With `wide_sel`=0, bits [31:16] of both operands have no effect on `product` or `sat_flag`.
- R10: In a cycle with `in_valid` low, `product` and `sat_flag` keep their previous values on the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe; operands and selects are captured when high |
| op_a | input | 32 | First operand; low 16 bits only in narrow precision |
| op_b | input | 32 | Second operand; low 16 bits only in narrow precision |
| wide_sel | input | 1 | 1 = 32-bit operands, 0 = 16-bit operands |
| sat_mode | input | 1 | 1 = clamp the most-negative pair, 0 = wrap |
| out_valid | output | 1 | High in the cycle a result is presented |
| product | output | 64 | Fractional product, sign-extended in narrow precision |
| sat_flag | output | 1 | Clamp or raw-product indication flag |

## Verification
The hardest condition to reach is the clamp. It needs both operands at the most negative value of the selected precision, with clamping mode on. A random source almost never produces that pair, and in narrow precision the upper operand halves must not disturb the match. The stimulus sweeps the full cross of 0x8000/0x80000000, the largest positive value, zero, minus one and plus one. It runs this sweep in both precisions and both modes, so both clamps and both wrapping outcomes come up on purpose. It then repeats the narrow corners with junk in the upper operand halves, and inserts idle gaps to test the hold behaviour.

// File: rtl/fmul_pkg.sv
package fmul_pkg;

    typedef enum logic {
        MODE_WRAP  = 1'b0,
        MODE_CLAMP = 1'b1
    } clamp_mode_e;

    typedef enum logic {
        PREC_NARROW = 1'b0,
        PREC_WIDE   = 1'b1
    } prec_e;

endpackage

// File: rtl/fmul_lane.sv
module fmul_lane #(
    parameter int W = 16
) (
    input  logic signed [W-1:0]   a,
    input  logic signed [W-1:0]   b,
    output logic        [2*W-1:0] frac,
    output logic                  top_ones,
    output logic                  both_min
);
    localparam int PW = 2 * W;
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

    logic signed [PW-1:0] raw;

    always_comb begin
        raw      = PW'(a) * PW'(b);
        frac     = {raw[PW-2:0], 1'b0};
        top_ones = raw[PW-1] & raw[PW-2];
        both_min = (a == MOST_NEG) && (b == MOST_NEG);
    end
endmodule

// File: rtl/fmul_pick.sv
module fmul_pick
    import fmul_pkg::*;
#(
    parameter int NW = 16,
    parameter int WW = 32
) (
    input  logic [2*NW-1:0] n_frac,
    input  logic            n_top,
    input  logic            n_min,
    input  logic [2*WW-1:0] w_frac,
    input  logic            w_top,
    input  logic            w_min,
    input  prec_e           prec,
    input  clamp_mode_e     mode,
    output logic [2*WW-1:0] prod,
    output logic            flag
);
    localparam int NP = 2 * NW;
    localparam int WP = 2 * WW;
    localparam logic [WP-1:0] N_CLAMP = {{(WP-NP+1){1'b0}}, {(NP-1){1'b1}}};
    localparam logic [WP-1:0] W_CLAMP = {1'b0, {(WP-1){1'b1}}};

    logic [WP-1:0] n_ext;

    always_comb begin
        n_ext = {{(WP-NP){n_frac[NP-1]}}, n_frac};
        if (prec == PREC_WIDE) begin
            if (mode == MODE_CLAMP && w_min) begin
                prod = W_CLAMP;
                flag = 1'b1;
            end else begin
                prod = w_frac;
                flag = w_top;
            end
        end else begin
            if (mode == MODE_CLAMP && n_min) begin
                prod = N_CLAMP;
                flag = 1'b1;
            end else begin
                prod = n_ext;
                flag = n_top;
            end
        end
    end
endmodule

// File: rtl/frac_mul_sat.sv
module frac_mul_sat
    import fmul_pkg::*;
#(
    parameter int NARROW_W = 16,
    parameter int WIDE_W   = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [WIDE_W-1:0]     op_a,
    input  logic [WIDE_W-1:0]     op_b,
    input  logic                  wide_sel,
    input  logic                  sat_mode,
    output logic                  out_valid,
    output logic [2*WIDE_W-1:0]   product,
    output logic                  sat_flag
);
    localparam int PW = 2 * WIDE_W;
    localparam int NP = 2 * NARROW_W;

    typedef struct packed {
        logic          vld;
        logic [PW-1:0] prod;
        logic          flag;
    } stage_t;

    stage_t stage_d, stage_q;

    logic [NP-1:0] n_frac;
    logic [PW-1:0] w_frac;
    logic          n_top, n_min, w_top, w_min;
    logic [PW-1:0] pick_prod;
    logic          pick_flag;

    generate
        if (WIDE_W >= NARROW_W) begin : g_lanes
            fmul_lane #(.W(NARROW_W)) narrow_i (
                .a        (op_a[NARROW_W-1:0]),
                .b        (op_b[NARROW_W-1:0]),
                .frac     (n_frac),
                .top_ones (n_top),
                .both_min (n_min)
            );
            fmul_lane #(.W(WIDE_W)) wide_i (
                .a        (op_a),
                .b        (op_b),
                .frac     (w_frac),
                .top_ones (w_top),
                .both_min (w_min)
            );
        end
    endgenerate

    fmul_pick #(.NW(NARROW_W), .WW(WIDE_W)) pick_i (
        .n_frac (n_frac),
        .n_top  (n_top),
        .n_min  (n_min),
        .w_frac (w_frac),
        .w_top  (w_top),
        .w_min  (w_min),
        .prec   (prec_e'(wide_sel)),
        .mode   (clamp_mode_e'(sat_mode)),
        .prod   (pick_prod),
        .flag   (pick_flag)
    );

    always_comb begin
        stage_d     = stage_q;
        stage_d.vld = in_valid;
        if (in_valid) begin
            stage_d.prod = pick_prod;
            stage_d.flag = pick_flag;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign out_valid = stage_q.vld;
    assign product   = stage_q.prod;
    assign sat_flag  = stage_q.flag;
endmodule

// File: rtl/frac_mul_sat_chk.sv
module frac_mul_sat_chk #(
    parameter int NARROW_W = 16,
    parameter int WIDE_W   = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic [WIDE_W-1:0]   op_a,
    input logic [WIDE_W-1:0]   op_b,
    input logic                wide_sel,
    input logic                sat_mode,
    input logic                out_valid,
    input logic [2*WIDE_W-1:0] product,
    input logic                sat_flag
);
    localparam int PW = 2 * WIDE_W;
    localparam int NP = 2 * NARROW_W;
    localparam logic [NARROW_W-1:0] N_MIN = {1'b1, {(NARROW_W-1){1'b0}}};
    localparam logic [WIDE_W-1:0]   W_MIN = {1'b1, {(WIDE_W-1){1'b0}}};
    localparam logic [PW-1:0] N_TOP = {{(PW-NP+1){1'b0}}, {(NP-1){1'b1}}};
    localparam logic [PW-1:0] W_TOP = {1'b0, {(PW-1){1'b1}}};

    p_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(product) && $stable(sat_flag)));

    p_clamp_narrow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sat_mode && !wide_sel &&
         op_a[NARROW_W-1:0] == N_MIN && op_b[NARROW_W-1:0] == N_MIN)
        |=> (product == N_TOP && sat_flag));

    p_clamp_wide_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sat_mode && wide_sel && op_a == W_MIN && op_b == W_MIN)
        |=> (product == W_TOP && sat_flag));

    p_sign_ext_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !wide_sel)
        |=> ((&product[PW-1:NP-1]) || !(|product[PW-1:NP-1])));

    p_odd_only_clamped_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && product[0]) |-> sat_flag);
endmodule

bind frac_mul_sat frac_mul_sat_chk #(.NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_a      (op_a),
    .op_b      (op_b),
    .wide_sel  (wide_sel),
    .sat_mode  (sat_mode),
    .out_valid (out_valid),
    .product   (product),
    .sat_flag  (sat_flag)
);

// File: tb/frac_mul_sat_tb_top.sv
module frac_mul_sat_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        wide_sel = 1'b0;
    logic        sat_mode = 1'b0;
    logic        out_valid;
    logic [63:0] product;
    logic        sat_flag;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit done     = 0;

    typedef struct {
        logic [63:0] prod;
        logic        flag;
        int          due;
        string       tag;
    } exp_t;

    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    frac_mul_sat dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op_a      (op_a),
        .op_b      (op_b),
        .wide_sel  (wide_sel),
        .sat_mode  (sat_mode),
        .out_valid (out_valid),
        .product   (product),
        .sat_flag  (sat_flag)
    );

    function automatic exp_t model(logic [31:0] a, logic [31:0] b, logic wide, logic sat);
        exp_t e;
        logic signed [63:0] rw;
        logic signed [31:0] rn;
        logic signed [31:0] sn;
        logic signed [15:0] a16, b16;
        e.due = 0;
        if (wide) begin
            if (sat && a == 32'h8000_0000 && b == 32'h8000_0000) begin
                e.prod = 64'h7FFF_FFFF_FFFF_FFFF; e.flag = 1'b1; e.tag = "R7";
            end else begin
                rw = 64'(signed'(a)) * 64'(signed'(b));
                e.prod = rw << 1;
                e.flag = rw[63] & rw[62];
                e.tag  = (a == 32'h8000_0000 && b == 32'h8000_0000) ? "R8" : "R3/R5";
            end
        end else begin
            a16 = a[15:0];
            b16 = b[15:0];
            if (sat && a16 == 16'sh8000 && b16 == 16'sh8000) begin
                e.prod = 64'h0000_0000_7FFF_FFFF; e.flag = 1'b1; e.tag = "R6";
            end else begin
                rn = 32'(a16) * 32'(b16);
                sn = rn << 1;
                e.prod = {{32{sn[31]}}, sn};
                e.flag = rn[31] & rn[30];
                e.tag  = (a16 == 16'sh8000 && b16 == 16'sh8000) ? "R8" : "R4/R5";
            end
            if (a[31:16] != 16'h0 || b[31:16] != 16'h0) e.tag = {e.tag, "/R9"};
        end
        return e;
    endfunction

    task automatic drive(logic [31:0] a, logic [31:0] b, logic wide, logic sat);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1; op_a = a; op_b = b; wide_sel = wide; sat_mode = sat;
        e = model(a, b, wide, sat);
        e.due = cyc + 1;
        sb.push_back(e);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0; op_a = $urandom; op_b = $urandom;
            wide_sel = 1'b1; sat_mode = 1'b1;
        end
    endtask

    // Monitor: pops the scoreboard when a result shows up; checks hold when idle.
    logic [63:0] last_prod = '0;
    logic        last_flag = 1'b0;
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n) begin
                if (out_valid) begin
                    exp_t e;
                    n_checks++;
                    if (sb.size() == 0) begin
                        n_fail++;
                        $display("FAIL R2: out_valid=1 at cycle %0d, expected 0 (no request)", cyc);
                    end else begin
                        e = sb.pop_front();
                        if (e.due != cyc) begin
                            n_fail++;
                            $display("FAIL R2: result at cycle %0d, expected cycle %0d", cyc, e.due);
                        end
                        if (product !== e.prod || sat_flag !== e.flag) begin
                            n_fail++;
                            $display("FAIL %s: product=%h flag=%b, expected product=%h flag=%b",
                                     e.tag, product, sat_flag, e.prod, e.flag);
                        end
                    end
                end else begin
                    n_checks++;
                    if (product !== last_prod || sat_flag !== last_flag) begin
                        n_fail++;
                        $display("FAIL R10: idle product=%h flag=%b, expected product=%h flag=%b",
                                 product, sat_flag, last_prod, last_flag);
                    end
                    if (sb.size() != 0 && sb[0].due == cyc) begin
                        n_fail++;
                        $display("FAIL R2: out_valid=0 at cycle %0d, expected 1", cyc);
                    end
                end
                last_prod = product;
                last_flag = sat_flag;
            end
        end
    end

    initial begin
        logic [15:0] nv [5];
        logic [31:0] wv [5];
        nv = '{16'h8000, 16'h7FFF, 16'h0000, 16'hFFFF, 16'h0001};
        wv = '{32'h8000_0000, 32'h7FFF_FFFF, 32'h0, 32'hFFFF_FFFF, 32'h1};

        // R1: reset state
        repeat (3) @(negedge clk);
        n_checks++;
        if (out_valid !== 1'b0 || product !== 64'h0 || sat_flag !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: in reset valid=%b product=%h flag=%b, expected 0/0/0",
                     out_valid, product, sat_flag);
        end
        rst_n = 1'b1;
        @(negedge clk);
        n_checks++;
        if (out_valid !== 1'b0 || product !== 64'h0 || sat_flag !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: after reset valid=%b product=%h flag=%b, expected 0/0/0",
                     out_valid, product, sat_flag);
        end

        // Boundary cross: both modes, both precisions
        for (int m = 0; m < 2; m++) begin
            for (int i = 0; i < 5; i++) begin
                for (int j = 0; j < 5; j++) begin
                    drive({16'h0, nv[i]}, {16'h0, nv[j]}, 1'b0, m[0]);
                    drive(wv[i], wv[j], 1'b1, m[0]);
                end
                idle(i % 3);
            end
        end

        // R9: junk in the upper halves for narrow precision
        for (int m = 0; m < 2; m++) begin
            for (int i = 0; i < 5; i++) begin
                for (int j = 0; j < 5; j++) begin
                    drive({16'hA5C3 ^ 16'(i * 4099), nv[i]}, {16'h5A3C + 16'(j * 77), nv[j]}, 1'b0, m[0]);
                end
            end
        end

        // Mixed operands
        for (int k = 0; k < 40; k++) begin
            drive($urandom, $urandom, k[0], k[1]);
            if (k % 7 == 0) idle(2);
        end

        idle(4);
        n_checks++;
        if (sb.size() != 0) begin
            n_fail++;
            $display("FAIL R2: %0d results missing, expected 0", sb.size());
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R2: watchdog expired at cycle %0d, expected completion", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule